// File: doc/BRIEF.md
# Paged Operand Address Generator

This block forms the 20-bit byte address of a data operand for a small 16-bit processor with a one-megabyte memory. It holds four 16-bit address registers and a 4-bit page register for each one. Register 0 is the program counter and register 1 is the workspace pointer. Each cycle, the instruction's mode, pointer select, displacement, zero-page index and short constant pick a register. The selected register's page becomes the top four address bits, and the lower sixteen bits are formed from the register and the instruction fields.

The displacement is merged into the register's word-index bits by a bitwise OR rather than an addition, so no carry chain is needed. Zero-page operands always go through the workspace pointer. A second 128-word area, the vector page, is chosen whenever the destination of the operand is the program counter or data register 0. Writing the program counter also reloads its page from the low four bits of the written value, so a 16-bit saved return address restores the full location.

The address output is combinational from the registers and the instruction fields. Register writes take effect at the next rising clock edge.

Top module: `opnd_addr_gen`

## Requirements
- R1: In mode 0 or 3 (pointer plus displacement), op_addr[15:5] equals the selected register's bits 15:5, and op_addr[4:1] equals the register's bits 4:1 bitwise ORed with disp[3:0], with no carry out of bit 4.
- R2: In every mode, op_addr[19:16] equals the page register of the register that supplies the address.
- R3: In modes 0, 1 and 3, op_addr[0] equals byte_hi when byte_acc is 1 and is 0 when byte_acc is 0 (word access).
- R4: In mode 1 (zero page), register 1 supplies the address regardless of ptr_sel. The address is {page1, reg1[15:9], vector bit, zp_idx[6:0], lane bit}, giving a 128-word area.
- R5: In mode 1, the vector bit (op_addr[8]) equals vec_dst, so the operand moves to the second 128-word area when its destination is the program counter or data register 0.
- R6: In mode 2 (register plus constant), op_addr[15:0] equals the selected register plus short_k (zero-extended, 0 to 31), taken modulo 2^16 without touching the page bits, and bit 0 is not forced.
- R7: When wr_en is 1, register wr_idx takes wr_data at the next rising edge. For index 1 to 3, its page register takes wr_page only when wr_page_en is 1 and is otherwise unchanged. No other register or page changes.
- R8: A write to register 0 loads page register 0 with wr_data[3:0] at the same edge, whatever wr_page_en and wr_page are.
- R9: Reset (rst_n low) clears page register 0. Page registers 1 to 3 and registers 1 to 3 keep their values through reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | 0 and 3: pointer plus displacement; 1: zero page; 2: register plus constant |
| ptr_sel | input | 2 | Address register select (ignored in mode 1) |
| disp | input | 4 | Displacement ORed into address bits 4:1 |
| zp_idx | input | 7 | Zero-page word index |
| short_k | input | 5 | Constant added in mode 2 |
| byte_acc | input | 1 | 1 for a byte access |
| byte_hi | input | 1 | Byte lane for byte access: 1 selects the most significant byte |
| vec_dst | input | 1 | Destination is the program counter or data register 0 |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 2 | Register to write |
| wr_data | input | 16 | Value written to the register |
| wr_page_en | input | 1 | Also load the page register for index 1 to 3 |
| wr_page | input | 4 | Page value for index 1 to 3 |
| op_addr | output | 20 | Operand address |

## Verification
The bench builds the block with its default parameters: four 16-bit registers, 4-bit pages, a 4-bit displacement, a 7-bit zero-page index and a 5-bit constant. These sizes are small enough to sweep all sixteen displacements against pointers whose low bits are already set, which exposes any adder used in place of the OR. They also make the 16-bit wrap of the register-plus-constant path reachable with a single constant near the top of the range. Every register index and every mode can be reached directly, so the bench checks the zero-page override of ptr_sel, the page reload on a program-counter write, and page retention through reset.

// File: rtl/oag_pkg.sv
package oag_pkg;
  localparam int ADDR_W  = 16;
  localparam int PAGE_W  = 4;
  localparam int NUM_REG = 4;
  localparam int DISP_W  = 4;
  localparam int ZP_W    = 7;
  localparam int K_W     = 5;
  localparam int WP_IDX  = 1;

  typedef enum logic [1:0] {
    AM_PTR_DISP  = 2'd0,
    AM_ZPAGE     = 2'd1,
    AM_REG_CONST = 2'd2,
    AM_PTR_ALT   = 2'd3
  } amode_e;
endpackage

// File: rtl/oag_regfile.sv
module oag_regfile #(
  parameter int NREG = oag_pkg::NUM_REG,
  parameter int AW   = oag_pkg::ADDR_W,
  parameter int PW   = oag_pkg::PAGE_W,
  localparam int IW  = $clog2(NREG)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [IW-1:0]            wr_idx,
  input  logic [AW-1:0]            wr_data,
  input  logic                     wr_page_en,
  input  logic [PW-1:0]            wr_page,
  output logic [NREG-1:0][AW-1:0]  regs,
  output logic [NREG-1:0][PW-1:0]  pages
);
  logic [NREG-1:0] wr_hit;
  logic            pc_write;

  assign pc_write = wr_hit[0];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [AW-1:0] r_q;
    logic [PW-1:0] p_q;

    assign wr_hit[g] = wr_en && (wr_idx == IW'(g));

    always_ff @(posedge clk) begin
      if (wr_hit[g]) r_q <= wr_data;
    end

    if (g == 0) begin : g_pc_page
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         p_q <= '0;
        else if (wr_hit[g]) p_q <= wr_data[PW-1:0];
      end
    end else begin : g_ptr_page
      always_ff @(posedge clk) begin
        if (wr_hit[g] && wr_page_en) p_q <= wr_page;
      end

      assert_page_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_hit[g] && wr_page_en) |=> $stable(pages[g]));
    end

    assign regs[g]  = r_q;
    assign pages[g] = p_q;
  end

  assert_reg_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> regs[$past(wr_idx)] == $past(wr_data));

  assert_pc_page_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pc_write |=> pages[0] == $past(wr_data[PW-1:0]));

  assert_pc_page_reset_R9: assert property (@(posedge clk)
    $rose(rst_n) |-> pages[0] == '0);
endmodule

// File: rtl/oag_ptr_sel.sv
module oag_ptr_sel #(
  parameter int NREG   = oag_pkg::NUM_REG,
  parameter int AW     = oag_pkg::ADDR_W,
  parameter int PW     = oag_pkg::PAGE_W,
  parameter int WP     = oag_pkg::WP_IDX,
  localparam int IW    = $clog2(NREG)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               mode,
  input  logic [IW-1:0]            ptr_sel,
  input  logic [NREG-1:0][AW-1:0]  regs,
  input  logic [NREG-1:0][PW-1:0]  pages,
  output logic [AW-1:0]            sel_reg,
  output logic [PW-1:0]            sel_page
);
  import oag_pkg::*;

  logic          zp_active;
  logic [IW-1:0] sel_idx;

  assign zp_active = (mode == AM_ZPAGE);
  assign sel_idx   = zp_active ? IW'(WP) : ptr_sel;
  assign sel_reg   = regs[sel_idx];
  assign sel_page  = pages[sel_idx];

  assert_zp_uses_wp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    zp_active |-> (sel_reg == regs[WP]) && (sel_page == pages[WP]));
endmodule

// File: rtl/oag_compose.sv
module oag_compose #(
  parameter int AW  = oag_pkg::ADDR_W,
  parameter int PW  = oag_pkg::PAGE_W,
  parameter int DW  = oag_pkg::DISP_W,
  parameter int ZW  = oag_pkg::ZP_W,
  parameter int KW  = oag_pkg::K_W,
  localparam int OW = AW + PW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [1:0]     mode,
  input  logic [AW-1:0]  sel_reg,
  input  logic [PW-1:0]  sel_page,
  input  logic [DW-1:0]  disp,
  input  logic [ZW-1:0]  zp_idx,
  input  logic [KW-1:0]  short_k,
  input  logic           byte_acc,
  input  logic           byte_hi,
  input  logic           vec_dst,
  output logic [OW-1:0]  op_addr
);
  import oag_pkg::*;

  // Word index (address bits AW-1..1) with the displacement merged by OR.
  function automatic logic [AW-2:0] f_or_field(input logic [AW-1:0] r, input logic [DW-1:0] d);
    return r[AW-1:1] | {{(AW-1-DW){1'b0}}, d};
  endfunction

  // Word index for a zero-page operand: pointer high bits, area bit, index.
  function automatic logic [AW-2:0] f_zpage(input logic [AW-1:0] r, input logic v,
                                            input logic [ZW-1:0] idx);
    return {r[AW-1:ZW+2], v, idx};
  endfunction

  function automatic logic [AW-1:0] f_reg_const(input logic [AW-1:0] r, input logic [KW-1:0] k);
    return r + {{(AW-KW){1'b0}}, k};
  endfunction

  logic          lane;
  logic [AW-2:0] disp_word;
  logic [AW-2:0] zp_word;
  logic [AW-1:0] const_sum;

  assign lane      = byte_acc & byte_hi;
  assign disp_word = f_or_field(sel_reg, disp);
  assign zp_word   = f_zpage(sel_reg, vec_dst, zp_idx);
  assign const_sum = f_reg_const(sel_reg, short_k);

  always_comb begin
    case (mode)
      AM_ZPAGE:     op_addr = {sel_page, zp_word, lane};
      AM_REG_CONST: op_addr = {sel_page, const_sum};
      default:      op_addr = {sel_page, disp_word, lane};
    endcase
  end

  assert_disp_or_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == AM_PTR_DISP || mode == AM_PTR_ALT) |->
      (op_addr[AW-1:DW+1] == sel_reg[AW-1:DW+1]) &&
      ((op_addr[DW:1] & disp) == disp) &&
      ((op_addr[DW:1] & sel_reg[DW:1]) == sel_reg[DW:1]) &&
      ($countones(op_addr[DW:1]) <= $countones(disp) + $countones(sel_reg[DW:1])));

  assert_page_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    op_addr[OW-1:AW] == sel_page);

  assert_word_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != AM_REG_CONST && !byte_acc) |-> op_addr[0] == 1'b0);

  assert_vector_area_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == AM_ZPAGE) |-> op_addr[ZW+1] == vec_dst);
endmodule

// File: rtl/opnd_addr_gen.sv
module opnd_addr_gen #(
  parameter int NREG = oag_pkg::NUM_REG,
  parameter int AW   = oag_pkg::ADDR_W,
  parameter int PW   = oag_pkg::PAGE_W,
  parameter int DW   = oag_pkg::DISP_W,
  parameter int ZW   = oag_pkg::ZP_W,
  parameter int KW   = oag_pkg::K_W,
  parameter int WP   = oag_pkg::WP_IDX,
  localparam int IW  = $clog2(NREG),
  localparam int OW  = AW + PW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic [IW-1:0] ptr_sel,
  input  logic [DW-1:0] disp,
  input  logic [ZW-1:0] zp_idx,
  input  logic [KW-1:0] short_k,
  input  logic          byte_acc,
  input  logic          byte_hi,
  input  logic          vec_dst,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [AW-1:0] wr_data,
  input  logic          wr_page_en,
  input  logic [PW-1:0] wr_page,
  output logic [OW-1:0] op_addr
);
  logic [NREG-1:0][AW-1:0] regs;
  logic [NREG-1:0][PW-1:0] pages;
  logic [AW-1:0]           sel_reg;
  logic [PW-1:0]           sel_page;

  oag_regfile #(.NREG(NREG), .AW(AW), .PW(PW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .wr_page_en(wr_page_en), .wr_page(wr_page), .regs(regs), .pages(pages)
  );

  oag_ptr_sel #(.NREG(NREG), .AW(AW), .PW(PW), .WP(WP)) u_sel (
    .clk(clk), .rst_n(rst_n), .mode(mode), .ptr_sel(ptr_sel), .regs(regs),
    .pages(pages), .sel_reg(sel_reg), .sel_page(sel_page)
  );

  oag_compose #(.AW(AW), .PW(PW), .DW(DW), .ZW(ZW), .KW(KW)) u_comp (
    .clk(clk), .rst_n(rst_n), .mode(mode), .sel_reg(sel_reg), .sel_page(sel_page),
    .disp(disp), .zp_idx(zp_idx), .short_k(short_k), .byte_acc(byte_acc),
    .byte_hi(byte_hi), .vec_dst(vec_dst), .op_addr(op_addr)
  );
endmodule

// File: tb/tb_opnd_addr_gen.sv
`timescale 1ns/1ps
module tb_opnd_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [1:0]  ptr_sel = 2'd0;
  logic [3:0]  disp = 4'd0;
  logic [6:0]  zp_idx = 7'd0;
  logic [4:0]  short_k = 5'd0;
  logic        byte_acc = 1'b0;
  logic        byte_hi = 1'b0;
  logic        vec_dst = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_idx = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic        wr_page_en = 1'b0;
  logic [3:0]  wr_page = 4'd0;
  logic [19:0] op_addr;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] m_reg [4];
  logic [3:0]  m_pg  [4];

  opnd_addr_gen dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .ptr_sel(ptr_sel), .disp(disp),
    .zp_idx(zp_idx), .short_k(short_k), .byte_acc(byte_acc), .byte_hi(byte_hi),
    .vec_dst(vec_dst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .wr_page_en(wr_page_en), .wr_page(wr_page), .op_addr(op_addr)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [19:0] got, input logic [19:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %05h expected %05h", req, got, exp);
    end
  endtask

  // Bench model: only the pages follow the write rules, values are plain copies.
  task automatic wr(input int idx, input logic [15:0] d, input logic pen, input logic [3:0] pg);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 2'(idx); wr_data = d; wr_page_en = pen; wr_page = pg;
    @(negedge clk);
    wr_en = 1'b0; wr_page_en = 1'b0;
    m_reg[idx] = d;
    if (idx == 0) m_pg[0] = d[3:0];
    else if (pen) m_pg[idx] = pg;
  endtask

  function automatic logic [19:0] e_ptr(input int i, input logic [3:0] d, input logic ba, input logic bh);
    logic [15:0] w;
    w = (m_reg[i] | {11'd0, d, 1'b0}) & 16'hFFFE;
    return {m_pg[i], w | {15'd0, ba & bh}};
  endfunction

  function automatic logic [19:0] e_zp(input logic [6:0] ix, input logic v, input logic ba, input logic bh);
    logic [15:0] w;
    w = (m_reg[1] & 16'hFE00) | (v ? 16'h0100 : 16'h0000) | ({9'd0, ix} << 1) | {15'd0, ba & bh};
    return {m_pg[1], w};
  endfunction

  task automatic t_reset;
    mode = 2'd0; ptr_sel = 2'd0; disp = 4'd0;
    #1;
    n_chk++;
    if (op_addr[19:16] !== 4'h0) begin
      n_bad++;
      $display("FAIL R9: PC page after reset got %h expected 0", op_addr[19:16]);
    end
  endtask

  task automatic t_or_disp;
    logic [15:0] ptrs [4] = '{16'h0006, 16'h001E, 16'hFFFF, 16'h1230};
    for (int p = 0; p < 4; p++) begin
      wr(2, ptrs[p], 1'b1, 4'(p + 3));
      mode = (p[0]) ? 2'd3 : 2'd0; ptr_sel = 2'd2; byte_acc = 1'b0;
      for (int d = 0; d < 16; d++) begin
        disp = 4'(d);
        #1;
        chk("R1/R2 or-displacement", op_addr, e_ptr(2, 4'(d), 1'b0, 1'b0));
      end
    end
    wr(2, 16'h0006, 1'b0, 4'h0);
    mode = 2'd0; disp = 4'd1; #1;
    chk("R1 no carry 0006|1", op_addr, {4'h6, 16'h0006});
    disp = 4'd4; #1;
    chk("R1 0006|4", op_addr, {4'h6, 16'h000E});
  endtask

  task automatic t_byte;
    wr(3, 16'h4440, 1'b1, 4'h2);
    mode = 2'd0; ptr_sel = 2'd3; disp = 4'd2;
    byte_acc = 1'b1; byte_hi = 1'b1; #1;
    chk("R3 byte high lane", op_addr, e_ptr(3, 4'd2, 1'b1, 1'b1));
    chk("R3 literal", op_addr, {4'h2, 16'h4445});
    byte_hi = 1'b0; #1;
    chk("R3 byte low lane", op_addr, {4'h2, 16'h4444});
    byte_acc = 1'b0; byte_hi = 1'b1; #1;
    chk("R3 word ignores lane", op_addr, {4'h2, 16'h4444});
    byte_hi = 1'b0;
  endtask

  task automatic t_zpage;
    wr(1, 16'hABCD, 1'b1, 4'h7);
    wr(0, 16'h2000, 1'b0, 4'h0);
    mode = 2'd1; vec_dst = 1'b0;
    for (int s = 0; s < 4; s++) begin
      ptr_sel = 2'(s); zp_idx = 7'h55; #1;
      chk("R4 zero page via reg1", op_addr, e_zp(7'h55, 1'b0, 1'b0, 1'b0));
    end
    zp_idx = 7'h7F; #1;
    chk("R4 literal top word", op_addr, {4'h7, 16'hAAFE});
    byte_acc = 1'b1; byte_hi = 1'b1; #1;
    chk("R3/R4 zero page byte", op_addr, e_zp(7'h7F, 1'b0, 1'b1, 1'b1));
    byte_acc = 1'b0; byte_hi = 1'b0;
  endtask

  task automatic t_vector;
    mode = 2'd1; ptr_sel = 2'd0; zp_idx = 7'h00; vec_dst = 1'b1; #1;
    chk("R5 vector area", op_addr, e_zp(7'h00, 1'b1, 1'b0, 1'b0));
    chk("R5 literal", op_addr, {4'h7, 16'hAB00});
    zp_idx = 7'h12; #1;
    chk("R5 vector index", op_addr, {4'h7, 16'hAB24});
    vec_dst = 1'b0; #1;
    chk("R5 normal area", op_addr, {4'h7, 16'hAA24});
  endtask

  task automatic t_regconst;
    wr(3, 16'hFFF0, 1'b1, 4'h9);
    mode = 2'd2; ptr_sel = 2'd3; byte_acc = 1'b1; byte_hi = 1'b0;
    short_k = 5'd31; #1;
    chk("R6 wrap keeps page", op_addr, {4'h9, 16'h000F});
    short_k = 5'd0; #1;
    chk("R6 zero constant", op_addr, {4'h9, 16'hFFF0});
    short_k = 5'd1; #1;
    chk("R6 bit0 not forced", op_addr, {4'h9, 16'hFFF1});
    byte_acc = 1'b0;
  endtask

  task automatic t_writes;
    wr(2, 16'h1000, 1'b1, 4'hB);
    wr(2, 16'h2000, 1'b0, 4'h4);
    mode = 2'd0; ptr_sel = 2'd2; disp = 4'd0; #1;
    chk("R7 value loads page held", op_addr, {4'hB, 16'h2000});
    wr(3, 16'h3000, 1'b1, 4'h1);
    #1;
    chk("R7 other index untouched", op_addr, {4'hB, 16'h2000});
    wr(2, 16'h2000, 1'b1, 4'h4);
    #1;
    chk("R7 page loads when enabled", op_addr, e_ptr(2, 4'd0, 1'b0, 1'b0));
  endtask

  task automatic t_pc_page;
    wr(0, 16'h1235, 1'b1, 4'hC);
    mode = 2'd0; ptr_sel = 2'd0; disp = 4'd0; #1;
    chk("R8 PC page from low bits", op_addr, {4'h5, 16'h1234});
    wr(0, 16'h8008, 1'b0, 4'h0);
    #1;
    chk("R8 PC page without enable", op_addr, {4'h8, 16'h8008});
    ptr_sel = 2'd1; #1;
    chk("R8 reg1 page unaffected", op_addr, {4'h7, 16'hABCC});
  endtask

  task automatic t_reset_retain;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    m_pg[0] = 4'h0;
    mode = 2'd0; disp = 4'd0; ptr_sel = 2'd0; #1;
    n_chk++;
    if (op_addr[19:16] !== 4'h0) begin
      n_bad++;
      $display("FAIL R9: PC page after second reset got %h expected 0", op_addr[19:16]);
    end
    ptr_sel = 2'd2; #1;
    chk("R9 reg2 kept through reset", op_addr, {4'h4, 16'h2000});
    ptr_sel = 2'd3; #1;
    chk("R9 reg3 kept through reset", op_addr, {4'h1, 16'h3000});
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin m_reg[i] = '0; m_pg[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_or_disp();
    t_byte();
    t_zpage();
    t_vector();
    t_regconst();
    t_writes();
    t_pc_page();
    t_reset_retain();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule